// File: doc/BRIEF.md
# Dual-Register Output Logic Cell

This block is one output logic cell of a programmable logic array. It holds two state registers, each fed by its own sum term from the array. Each register is set up on its own as a data register or a toggle register. It is clocked either by the shared clock pin or by its own product-term clock. Both registers always return their state to the array as feedback. One of them, picked by a configuration input, can also drive the cell's bidirectional pin. The pin driver is gated by the cell's own output-enable term. While the driver is off, the pin value seen by the array comes from outside.

The cell runs on a fast sampling clock. The pin clock and the product-term clocks are sampled on it, and a register updates in the sampling cycle where its selected source is first seen high after being low. Each register has its own asynchronous clear. A preset input, shared with all other cells, sets a register to 1 on that register's next active edge. A test preload writes register contents directly, whatever the selected clock is doing. A global active-low reset clears everything, standing in for the power-up clear. The cell resolves updates in a fixed order: asynchronous clear first, then preload, then preset, then the normal data or toggle update.

Top module: `dual_reg_cell`

## Requirements
- R1: With `cfgToggle[i]`=0, register i takes the value of `sumTerm[i]` on its active edge.
- R2: With `cfgToggle[i]`=1, register i inverts on its active edge when `sumTerm[i]` is 1 and holds when it is 0.
- R3: An active edge for register i is a sampling cycle in which its selected source is 1 and was 0 in the previous sampling cycle. The source is `pinClk` when `cfgPinClk[i]`=1 and `ptClk[i]` when it is 0. Edges on the source that is not selected leave the register unchanged.
- R4: While `arstIn[i]` is 1, register i reads 0 at once, without waiting for a sampling edge.
- R5: When `presetIn` is 1 on an active edge of register i, the register becomes 1 instead of its data or toggle result. On cycles with no active edge, preset has no effect.
- R6: When `preloadEn` is 1 at a sampling edge, every register not being cleared takes `preloadData[i]`. This happens with or without an active edge, and preload wins over preset.
- R7: The asynchronous clear of a register wins over preload, preset and the normal update.
- R8: While `rstN` is 0, both registers read 0 and the edge history is cleared. The first sampled high clock after reset therefore counts as an edge.
- R9: `padOut` carries register `cfgOutSel` (0 selects register 0, 1 selects register 1). `padOe` follows `oeTerm`.
- R10: `pinToArray` equals `padOut` when `padOe` is 1 and `padIn` when it is 0. `feedback` always carries both registers, bit i being register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low global clear (power-up) |
| pinClk | input | 1 | Shared clock pin, sampled |
| ptClk | input | 2 | Product-term clock per register, sampled |
| cfgToggle | input | 2 | Per register: 1 toggle mode, 0 data mode |
| cfgPinClk | input | 2 | Per register: 1 pin clock, 0 product-term clock |
| cfgOutSel | input | 1 | Index of the register that drives the pin |
| sumTerm | input | 2 | Sum term per register |
| arstIn | input | 2 | Asynchronous clear per register |
| presetIn | input | 1 | Shared synchronous preset |
| preloadEn | input | 1 | Test preload strobe |
| preloadData | input | 2 | Test preload values |
| oeTerm | input | 1 | Output-enable product term |
| padIn | input | 1 | Value on the pin from outside |
| padOut | output | 1 | Value driven onto the pin |
| padOe | output | 1 | Pin driver enable |
| pinToArray | output | 1 | Pin value returned to the array |
| feedback | output | 2 | Both register states to the array |

## Verification
The stimulus runs through four static setups that cover data and toggle mode on both clock sources and both output selections. Sum terms, both clock sources, clears, preset, preload, output enable and pin input change at random within each setup. Because the clock source that is not selected also toggles at random, an update on the wrong source shows up as a mismatch. Clear, preload and preset arrive at mixed rates, often together, so each priority pair is tried in both orders of importance. A mid-run global reset with a clock already high tests that the edge history is cleared.

// File: rtl/dual_reg_cell_pkg.sv
package dual_reg_cell_pkg;
  typedef struct packed {
    logic preset;
    logic preload;
  } cellStrobe_t;
endpackage

// File: rtl/dual_reg_cell_ctrl.sv
module dual_reg_cell_ctrl
  import dual_reg_cell_pkg::*;
#(
  parameter int NUM_REGS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinClk,
  input  logic [NUM_REGS-1:0] ptClk,
  input  logic [NUM_REGS-1:0] cfgPinClk,
  input  logic                presetIn,
  input  logic                preloadEn,
  output logic [NUM_REGS-1:0] clkHit,
  output cellStrobe_t         strobe
);
  logic                pinPrevQ;
  logic [NUM_REGS-1:0] ptPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrevQ <= 1'b0;
      ptPrevQ  <= '0;
    end else begin
      pinPrevQ <= pinClk;
      ptPrevQ  <= ptClk;
    end
  end

  logic                pinRise;
  logic [NUM_REGS-1:0] ptRise;
  assign pinRise = pinClk & ~pinPrevQ;
  assign ptRise  = ptClk & ~ptPrevQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign clkHit[i] = cfgPinClk[i] ? pinRise : ptRise[i];
  end

  assign strobe.preset  = presetIn;
  assign strobe.preload = preloadEn;
endmodule

// File: rtl/dual_reg_cell_dp.sv
module dual_reg_cell_dp
  import dual_reg_cell_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int SEL_W    = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] clkHit,
  input  cellStrobe_t         strobe,
  input  logic [NUM_REGS-1:0] cfgToggle,
  input  logic [SEL_W-1:0]    cfgOutSel,
  input  logic [NUM_REGS-1:0] sumTerm,
  input  logic [NUM_REGS-1:0] arstIn,
  input  logic [NUM_REGS-1:0] preloadData,
  input  logic                oeTerm,
  input  logic                padIn,
  output logic                padOut,
  output logic                padOe,
  output logic                pinToArray,
  output logic [NUM_REGS-1:0] feedback
);
  logic [NUM_REGS-1:0] stateQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic bitQ;
    logic nextBit;

    always_comb begin
      if (strobe.preload)      nextBit = preloadData[i];
      else if (!clkHit[i])     nextBit = bitQ;
      else if (strobe.preset)  nextBit = 1'b1;
      else if (cfgToggle[i])   nextBit = bitQ ^ sumTerm[i];
      else                     nextBit = sumTerm[i];
    end

    always_ff @(posedge clk or negedge rstN or posedge arstIn[i]) begin
      if (!rstN)          bitQ <= 1'b0;
      else if (arstIn[i]) bitQ <= 1'b0;
      else                bitQ <= nextBit;
    end

    assign stateQ[i] = bitQ;

    AST_ARST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      arstIn[i] |-> !stateQ[i]); // R4

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.preload && !arstIn[i]) |=> (arstIn[i] || stateQ[i] == $past(preloadData[i]))); // R6

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (clkHit[i] && strobe.preset && !strobe.preload && !arstIn[i]) |=> (arstIn[i] || stateQ[i])); // R5

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      (!clkHit[i] && !strobe.preload && !arstIn[i] && !stateQ[i]) |=> (arstIn[i] || !stateQ[i])); // R3
  end

  assign feedback   = stateQ;
  assign padOut     = stateQ[cfgOutSel];
  assign padOe      = oeTerm;
  assign pinToArray = padOe ? padOut : padIn;
endmodule

// File: rtl/dual_reg_cell.sv
module dual_reg_cell
  import dual_reg_cell_pkg::*;
#(
  parameter int NUM_REGS = 2,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinClk,
  input  logic [NUM_REGS-1:0] ptClk,
  input  logic [NUM_REGS-1:0] cfgToggle,
  input  logic [NUM_REGS-1:0] cfgPinClk,
  input  logic [SEL_W-1:0]    cfgOutSel,
  input  logic [NUM_REGS-1:0] sumTerm,
  input  logic [NUM_REGS-1:0] arstIn,
  input  logic                presetIn,
  input  logic                preloadEn,
  input  logic [NUM_REGS-1:0] preloadData,
  input  logic                oeTerm,
  input  logic                padIn,
  output logic                padOut,
  output logic                padOe,
  output logic                pinToArray,
  output logic [NUM_REGS-1:0] feedback
);
  logic [NUM_REGS-1:0] clkHit;
  cellStrobe_t         strobe;

  dual_reg_cell_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinClk(pinClk), .ptClk(ptClk),
    .cfgPinClk(cfgPinClk), .presetIn(presetIn), .preloadEn(preloadEn),
    .clkHit(clkHit), .strobe(strobe)
  );

  dual_reg_cell_dp #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .clkHit(clkHit), .strobe(strobe),
    .cfgToggle(cfgToggle), .cfgOutSel(cfgOutSel), .sumTerm(sumTerm),
    .arstIn(arstIn), .preloadData(preloadData), .oeTerm(oeTerm),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pinToArray(pinToArray), .feedback(feedback)
  );
endmodule

// File: tb/dual_reg_cell_bench.sv
module dual_reg_cell_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, pinClk, cfgOutSel, presetIn, preloadEn, oeTerm, padIn;
  logic [1:0] ptClk, cfgToggle, cfgPinClk, sumTerm, arstIn, preloadData;
  logic       padOut, padOe, pinToArray;
  logic [1:0] feedback;

  dual_reg_cell u_dual_reg_cell (
    .clk(clk), .rstN(rstN), .pinClk(pinClk), .ptClk(ptClk),
    .cfgToggle(cfgToggle), .cfgPinClk(cfgPinClk), .cfgOutSel(cfgOutSel),
    .sumTerm(sumTerm), .arstIn(arstIn), .presetIn(presetIn),
    .preloadEn(preloadEn), .preloadData(preloadData), .oeTerm(oeTerm),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pinToArray(pinToArray), .feedback(feedback)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  int mState[2];
  int mPrevPin;
  int mPrevPt[2];
  string why[2];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin mState[i] = 0; mPrevPt[i] = 0; why[i] = "R8"; end
    mPrevPin = 0;
  endtask

  task automatic modelEdge();
    for (int i = 0; i < 2; i++) begin
      int hit;
      hit = cfgPinClk[i] ? (pinClk && !mPrevPin) : (ptClk[i] && !mPrevPt[i]);
      if (arstIn[i])       begin mState[i] = 0; why[i] = "R7"; end
      else if (preloadEn)  begin mState[i] = preloadData[i]; why[i] = "R6"; end
      else if (!hit)       begin why[i] = "R3"; end
      else if (presetIn)   begin mState[i] = 1; why[i] = "R5"; end
      else if (cfgToggle[i]) begin mState[i] = mState[i] ^ sumTerm[i]; why[i] = "R2"; end
      else                 begin mState[i] = sumTerm[i]; why[i] = "R1"; end
    end
    mPrevPin = pinClk;
    for (int i = 0; i < 2; i++) mPrevPt[i] = ptClk[i];
  endtask

  task automatic compareAll();
    int expOut;
    for (int i = 0; i < 2; i++) check(why[i], feedback[i], mState[i]);
    expOut = mState[cfgOutSel];
    check("R9 padOut", padOut, expOut);
    check("R9 padOe", padOe, oeTerm);
    check("R10 pinToArray", pinToArray, oeTerm ? expOut : padIn);
  endtask

  // one sampling cycle with random stimulus; rates out of 16
  task automatic step(int arstRate, int preloadRate, int presetRate);
    @(negedge clk);
    compareAll();
    pinClk      = $urandom_range(0, 1);
    ptClk       = 2'($urandom_range(0, 3));
    sumTerm     = 2'($urandom_range(0, 3));
    for (int i = 0; i < 2; i++) arstIn[i] = ($urandom_range(0, 15) < arstRate);
    preloadEn   = ($urandom_range(0, 15) < preloadRate);
    preloadData = 2'($urandom_range(0, 3));
    presetIn    = ($urandom_range(0, 15) < presetRate);
    oeTerm      = $urandom_range(0, 1);
    padIn       = $urandom_range(0, 1);
    #1;
    for (int i = 0; i < 2; i++)
      if (arstIn[i]) begin
        mState[i] = 0; why[i] = "R4";
        check("R4 immediate clear", feedback[i], 0);
      end
    @(posedge clk);
    #1;
    modelEdge();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rstN = 0; pinClk = 0; ptClk = 0; cfgToggle = 0; cfgPinClk = 0; cfgOutSel = 0;
    sumTerm = 0; arstIn = 0; presetIn = 0; preloadEn = 0; preloadData = 0;
    oeTerm = 0; padIn = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset feedback", feedback, 0);
    check("R8 reset padOut", padOut, 0);
    rstN = 1;

    // directed: data mode on product-term clock, pin clock toggles ignored (R3)
    @(negedge clk); sumTerm = 2'b11; pinClk = 1; cfgPinClk = 2'b00;
    @(negedge clk); check("R3 other source ignored", feedback, 0);
    ptClk = 2'b01;
    @(negedge clk); check("R1 data load on own edge", feedback, 2'b01);
    pinClk = 0; ptClk = 0;
    @(posedge clk); #1;
    mState[0] = 1; mState[1] = 0; mPrevPin = 0; mPrevPt[0] = 0; mPrevPt[1] = 0;
    why[0] = "R1"; why[1] = "R3";

    for (int phase = 0; phase < 4; phase++) begin
      cfgToggle = 2'(phase);
      cfgPinClk = 2'(phase ^ 1);
      cfgOutSel = phase[1];
      for (int n = 0; n < 400; n++) step(1, 2, 5);
      for (int n = 0; n < 150; n++) step(0, 0, 0);
      for (int n = 0; n < 150; n++) step(4, 8, 8);
    end

    // mid-run reset with the clock already high (R8)
    @(negedge clk);
    compareAll();
    arstIn = 0; preloadEn = 0; presetIn = 0;
    cfgPinClk = 2'b11; cfgToggle = 2'b00; sumTerm = 2'b11; pinClk = 1;
    rstN = 0; #1;
    modelReset();
    check("R8 async global clear", feedback, 0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1; modelEdge();
    @(negedge clk); check("R8 first high after reset is an edge", feedback, 2'b11);
    compareAll();
    for (int n = 0; n < 200; n++) step(2, 3, 4);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule